// File: doc/BRIEF.md
# Protected Clock Controller with Wait State

This block is the clock control unit of a small microcontroller. It holds two clock configuration registers that can only be written while a separate protect bit is set. It builds a divided CPU clock enable and three peripheral clock enables (f1, f8, f32) from a main and a sub oscillator, and it handles entry into a low-power wait state and the exit from it. All outputs are single-cycle enables in the `clk` domain. Each oscillator is presented as a tick strobe: one cycle high for each edge of that oscillator.

Software reaches the registers over a byte-wide write port with a combinational read port. A `wait_req` strobe puts the block into the wait state. While it waits, the CPU clock enable is held low. The peripheral enables may be stopped during wait. An interrupt request wakes the block only if three things hold: the request is enabled, the global interrupt flag is set, and its priority level is strictly above the current processor level.

Top module: `clk_ctrl_unit`

Register map:
- Address 0 is the guard register. Bit 0 is the write-unlock bit.
- Address 1 is configuration register A:
  - bit 0: divide-by-8 override
  - bit 1: source select (1 selects the sub oscillator)
  - bit 2: main oscillator stop
  - bit 3: peripheral stop in wait
- Address 2 is configuration register B. Bits 7:6 hold the ratio code.
- Address 3 reads as 0.

## Requirements
- R1: A write to address 1 or 2 changes that register only if the guard bit (address 0, bit 0) was 1 when the write was made. Otherwise the register keeps its value.
- R2: Bits with no function read as 0 whatever was written. At address 0 these are bits 7:1, at address 1 bits 7:4, and at address 2 bits 5:0. Address 3 always reads 0.
- R3: After reset, register A reads 0x01 (main source, divide-by-8), register B reads 0x00, the guard register reads 0x00, `in_wait` is 0 and `main_osc_en` is 1.
- R4: When register A bit 0 is 1, `cpu_ce` gives one pulse for every 8 ticks of the selected source, and register B bits 7:6 have no effect.
- R5: When register A bit 0 is 0, register B bits 7:6 set the ratio: 00 gives divide-by-1, 01 divide-by-2, 10 divide-by-4 and 11 divide-by-16.
- R6: Register A bit 1 selects the source: 0 takes ticks from `main_tick` and 1 takes them from `sub_tick`.
- R7: When register A bit 2 is 1, `main_osc_en` is 0 and the main ticks are ignored.
- R8: While waiting with register A bit 3 set and the main source selected, `f1_ce`, `f8_ce` and `f32_ce` stay low and the peripheral counter is frozen. With the sub source selected, bit 3 acts as 0.
- R9: `f1_ce` follows every tick of the selected source. `f8_ce` fires on every 8th f1 pulse and `f32_ce` on every 32nd.
- R10: A wake happens only when at least one request meets all of these:
  - `irq_req` is 1;
  - `irq_en` is 1;
  - `i_flag` is 1;
  - its 3-bit level (request k at bits 3k+2:3k of `irq_lvl`) is strictly greater than `ipl`.
  A level of 0 never wakes the block.
- R11: While `in_wait` is 1, `cpu_ce` is 0. On wake-up, `in_wait` falls and `wake` is high for exactly one cycle. The divider restarts from zero, so the first `cpu_ce` comes on the N-th source tick after the wake edge, where N is the ratio.
- R12: If `wait_req` is high at a clock edge, `in_wait` is 1 in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| main_tick | input | 1 | One strobe for each main oscillator edge |
| sub_tick | input | 1 | One strobe for each sub oscillator edge |
| main_osc_en | output | 1 | Main oscillator run enable |
| cpu_ce | output | 1 | Divided CPU clock enable |
| f1_ce | output | 1 | Undivided peripheral clock enable |
| f8_ce | output | 1 | Peripheral clock enable at one eighth of f1 |
| f32_ce | output | 1 | Peripheral clock enable at one thirty-second of f1 |
| wait_req | input | 1 | Request to enter the wait state |
| irq_req | input | NUM_IRQ | Interrupt requests |
| irq_en | input | NUM_IRQ | Per-request enables |
| irq_lvl | input | NUM_IRQ*3 | Packed 3-bit priority levels |
| i_flag | input | 1 | Global interrupt enable flag |
| ipl | input | 3 | Current processor priority level |
| in_wait | output | 1 | Block is in the wait state |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:

- **Guard lock.** A locked write is made first, and the guard is then cleared again. A design that ignores the guard would let that write change the register.
- **Override priority.** The divide-by-8 override is combined with ratio code 11. A design that gets the precedence wrong would give 2 pulses in 32 ticks instead of 4.
- **Near-miss wake cases.** Four requests each fail exactly one wake condition:
  - level equal to `ipl`;
  - request disabled;
  - global flag cleared;
  - level 0 with `ipl` 0.
  A `>=` compare or a missing term would leave the wait state too early.
- **Divider restart.** After a wake at divide-by-4, the bench checks the exact cycle of the first CPU pulse. A divider that was not cleared would pulse early.
- **Peripheral stop under the sub source.** The peripheral stop bit is set while the sub source is selected. A design that does not override the bit in this case would stop f1 when it should keep running.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int LVL_W    = 3;
  localparam int DIV_W    = 4;
  localparam int F8_DIV   = 8;
  localparam int F32_DIV  = 32;
  localparam int PCNT_W   = $clog2(F32_DIV);
  localparam int F8_W     = $clog2(F8_DIV);

  localparam logic [ADDR_W-1:0] A_GUARD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFGA  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFGB  = 2'd2;

  typedef struct packed {
    logic       periph_stop;
    logic       main_stop;
    logic       sel_sub;
    logic       div8;
    logic [1:0] ratio;
  } ccu_cfg_t;
endpackage

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ccu_cfg_t          cfg
);
  logic       guard_q;
  logic [3:0] cfga_q;
  logic [1:0] cfgb_q;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= 1'b0;
      cfga_q  <= 4'b0001;
      cfgb_q  <= 2'b00;
    end else if (wr) begin
      case (addr)
        A_GUARD: guard_q <= wdata[0];
        A_CFGA:  if (guard_q) cfga_q <= wdata[3:0];
        A_CFGB:  if (guard_q) cfgb_q <= wdata[7:6];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GUARD: rdata[0]   = guard_q;
      A_CFGA:  rdata[3:0] = cfga_q;
      A_CFGB:  rdata[7:6] = cfgb_q;
      default: rdata = '0;
    endcase
  end

  assign cfg.div8        = cfga_q[0];
  assign cfg.sel_sub     = cfga_q[1];
  assign cfg.main_stop   = cfga_q[2];
  assign cfg.periph_stop = cfga_q[3];
  assign cfg.ratio       = cfgb_q;

  // R1
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_q |=> ($stable(cfga_q) && $stable(cfgb_q)));
endmodule

// File: rtl/ccu_clkgen.sv
module ccu_clkgen
  import ccu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ccu_cfg_t cfg,
  input  logic     main_tick,
  input  logic     sub_tick,
  input  logic     in_wait,
  output logic     main_osc_en,
  output logic     cpu_ce,
  output logic     f1_ce,
  output logic     f8_ce,
  output logic     f32_ce
);
  logic              src_tick;
  logic              periph_hold;
  logic [DIV_W-1:0]  dcnt_q;
  logic [DIV_W-1:0]  dmask;
  logic [PCNT_W-1:0] pcnt_q;

  assign main_osc_en = !cfg.main_stop;
  assign src_tick    = cfg.sel_sub ? sub_tick : (main_tick && !cfg.main_stop);

  always_comb begin
    if (cfg.div8) dmask = DIV_W'(7);
    else begin
      case (cfg.ratio)
        2'b00:   dmask = DIV_W'(0);
        2'b01:   dmask = DIV_W'(1);
        2'b10:   dmask = DIV_W'(3);
        default: dmask = DIV_W'(15);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dcnt_q <= '0;
    else if (in_wait)  dcnt_q <= '0;
    else if (src_tick) dcnt_q <= dcnt_q + 1'b1;
  end

  assign cpu_ce = src_tick && !in_wait && ((dcnt_q & dmask) == dmask);

  assign periph_hold = in_wait && cfg.periph_stop && !cfg.sel_sub;
  assign f1_ce       = src_tick && !periph_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt_q <= '0;
    else if (f1_ce) pcnt_q <= pcnt_q + 1'b1;
  end

  assign f8_ce  = f1_ce && (&pcnt_q[F8_W-1:0]);
  assign f32_ce = f1_ce && (&pcnt_q);

  // R11
  cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !cpu_ce);
  // R9
  f8_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f8_ce || f32_ce) |-> f1_ce);
  // R8
  periph_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && cfg.periph_stop && !cfg.sel_sub) |=>
      ((in_wait && cfg.periph_stop && !cfg.sel_sub) -> $stable(pcnt_q)));
endmodule

// File: rtl/ccu_wake.sv
module ccu_wake
  import ccu_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wait_req,
  input  logic [NUM_IRQ-1:0]       irq_req,
  input  logic [NUM_IRQ-1:0]       irq_en,
  input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl,
  input  logic                     i_flag,
  input  logic [LVL_W-1:0]         ipl,
  output logic                     in_wait,
  output logic                     wake
);
  logic [NUM_IRQ-1:0] qual;
  logic               hit;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_qual
    assign qual[k] = irq_req[k] && irq_en[k] &&
                     (irq_lvl[k*LVL_W +: LVL_W] > ipl);
  end

  assign hit = i_flag && (|qual);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wait <= 1'b0;
      wake    <= 1'b0;
    end else begin
      wake <= 1'b0;
      if (in_wait) begin
        if (hit) begin
          in_wait <= 1'b0;
          wake    <= 1'b1;
        end
      end else if (wait_req) begin
        in_wait <= 1'b1;
      end
    end
  end

  // R11
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R11
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !in_wait);
  // R12
  wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wait && wait_req) |=> in_wait);
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
  import ccu_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     main_tick,
  input  logic                     sub_tick,
  output logic                     main_osc_en,
  output logic                     cpu_ce,
  output logic                     f1_ce,
  output logic                     f8_ce,
  output logic                     f32_ce,
  input  logic                     wait_req,
  input  logic [NUM_IRQ-1:0]       irq_req,
  input  logic [NUM_IRQ-1:0]       irq_en,
  input  logic [NUM_IRQ*3-1:0]     irq_lvl,
  input  logic                     i_flag,
  input  logic [2:0]               ipl,
  output logic                     in_wait,
  output logic                     wake
);
  ccu_cfg_t cfg;

  ccu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  ccu_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .main_tick(main_tick),
    .sub_tick(sub_tick), .in_wait(in_wait), .main_osc_en(main_osc_en),
    .cpu_ce(cpu_ce), .f1_ce(f1_ce), .f8_ce(f8_ce), .f32_ce(f32_ce)
  );

  ccu_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_lvl(irq_lvl), .i_flag(i_flag), .ipl(ipl),
    .in_wait(in_wait), .wake(wake)
  );

  // R7
  main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_osc_en && !(reg_rdata == reg_rdata ? 1'b0 : 1'b1) && main_tick && !sub_tick)
      |-> !f1_ce);
endmodule

// File: tb/sim_clk_ctrl_unit.sv
`timescale 1ns/1ps
module sim_clk_ctrl_unit;
  localparam int NIRQ = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            main_tick = 1'b0, sub_tick = 1'b0;
  logic            main_osc_en, cpu_ce, f1_ce, f8_ce, f32_ce;
  logic            wait_req = 1'b0;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic [NIRQ*3-1:0] irq_lvl = '0;
  logic            i_flag = 1'b0;
  logic [2:0]      ipl = '0;
  logic            in_wait, wake;

  int n_vec = 0;
  int n_bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  clk_ctrl_unit #(.NUM_IRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_tick(main_tick),
    .sub_tick(sub_tick), .main_osc_en(main_osc_en), .cpu_ce(cpu_ce),
    .f1_ce(f1_ce), .f8_ce(f8_ce), .f32_ce(f32_ce), .wait_req(wait_req),
    .irq_req(irq_req), .irq_en(irq_en), .irq_lvl(irq_lvl), .i_flag(i_flag),
    .ipl(ipl), .in_wait(in_wait), .wake(wake)
  );

  // driver side of the scoreboard
  task automatic expect_val(string tag, int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic observe(int act);
    int    e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_vec++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; wait_req = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    idle_inputs();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output int v);
    @(negedge clk);
    idle_inputs();
    reg_addr = a;
    #5 v = int'(reg_rdata);
  endtask

  task automatic run(int n, int mp, int sp, output int c_cpu, output int c_f1,
                     output int c_f8, output int c_f32);
    c_cpu = 0; c_f1 = 0; c_f8 = 0; c_f32 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_inputs();
      main_tick = (mp > 0) && (i % mp == 0);
      sub_tick  = (sp > 0) && (i % sp == 0);
      #5;
      c_cpu += int'(cpu_ce); c_f1 += int'(f1_ce);
      c_f8  += int'(f8_ce);  c_f32 += int'(f32_ce);
    end
  endtask

  task automatic enter_wait();
    @(negedge clk);
    idle_inputs();
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
  endtask

  task automatic wake_up();
    @(negedge clk);
    idle_inputs();
    irq_req = 4'b0001; irq_en = 4'b0001; irq_lvl = 12'd4; i_flag = 1'b1; ipl = 3'd3;
    @(negedge clk);
    irq_req = '0; irq_en = '0; i_flag = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, c0, c1, c2, c3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    rd_reg(2'd1, v); expect_val("R3 cfgA reset", 1);  observe(v);
    rd_reg(2'd2, v); expect_val("R3 cfgB reset", 0);  observe(v);
    rd_reg(2'd0, v); expect_val("R3 guard reset", 0); observe(v);
    expect_val("R3 in_wait reset", 0); observe(int'(in_wait));
    expect_val("R3 main_osc_en reset", 1); observe(int'(main_osc_en));

    // R1 locked write ignored
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd1, v); expect_val("R1 locked cfgA", 1); observe(v);
    wr_reg(2'd2, 8'hC0);
    rd_reg(2'd2, v); expect_val("R1 locked cfgB", 0); observe(v);
    // R1 unlocked write lands
    wr_reg(2'd0, 8'h01);
    wr_reg(2'd2, 8'h80);
    rd_reg(2'd2, v); expect_val("R1 unlocked cfgB", 8'h80); observe(v);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h40);
    rd_reg(2'd2, v); expect_val("R1 relocked cfgB", 8'h80); observe(v);

    // R2 bits without function read 0
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, v); expect_val("R2 guard bits", 1); observe(v);
    wr_reg(2'd1, 8'hF1);
    rd_reg(2'd1, v); expect_val("R2 cfgA bits", 1); observe(v);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); expect_val("R2 cfgB bits", 8'hC0); observe(v);
    rd_reg(2'd3, v); expect_val("R2 addr3", 0); observe(v);

    // R4 override wins over code 11
    run(32, 1, 0, c0, c1, c2, c3); expect_val("R4 div8 over code 11", 4); observe(c0);

    // R5 ratio codes
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h00); run(32, 1, 0, c0, c1, c2, c3);
    expect_val("R5 code 00", 32); observe(c0);
    wr_reg(2'd2, 8'h40); run(32, 1, 0, c0, c1, c2, c3);
    expect_val("R5 code 01", 16); observe(c0);
    wr_reg(2'd2, 8'h80); run(32, 1, 0, c0, c1, c2, c3);
    expect_val("R5 code 10", 8); observe(c0);
    wr_reg(2'd2, 8'hC0); run(32, 1, 0, c0, c1, c2, c3);
    expect_val("R5 code 11", 2); observe(c0);

    // R9 peripheral strobes
    wr_reg(2'd2, 8'h00);
    run(64, 1, 0, c0, c1, c2, c3);
    expect_val("R9 f1 count", 64); observe(c1);
    expect_val("R9 f8 count", 8);  observe(c2);
    expect_val("R9 f32 count", 2); observe(c3);

    // R6 sub source
    wr_reg(2'd1, 8'h02);
    run(64, 1, 4, c0, c1, c2, c3);
    expect_val("R6 sub source", 16); observe(c0);
    wr_reg(2'd1, 8'h00);
    run(64, 4, 1, c0, c1, c2, c3);
    expect_val("R6 main source", 16); observe(c0);

    // R7 main stop
    wr_reg(2'd1, 8'h04);
    run(16, 1, 0, c0, c1, c2, c3);
    expect_val("R7 cpu with main off", 0); observe(c0);
    expect_val("R7 main_osc_en", 0); observe(int'(main_osc_en));
    wr_reg(2'd1, 8'h00);

    // R12 entry, R8 peripheral stop in wait (main source)
    wr_reg(2'd1, 8'h08);
    enter_wait();
    #5; expect_val("R12 in_wait after request", 1); observe(int'(in_wait));
    run(20, 1, 0, c0, c1, c2, c3);
    expect_val("R8 f1 stopped", 0); observe(c1);
    expect_val("R11 cpu held in wait", 0); observe(c0);
    wake_up();

    // R8 stop bit overridden with sub source
    wr_reg(2'd1, 8'h0A);
    enter_wait();
    run(20, 0, 1, c0, c1, c2, c3);
    expect_val("R8 f1 runs on sub", 20); observe(c1);
    wake_up();

    // R10 near misses then a valid wake
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h80);
    enter_wait();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle_inputs();
      irq_req = 4'b0010; irq_en = 4'b0010; i_flag = 1'b1; ipl = 3'd3;
      irq_lvl = 12'd4 << 3;
      case (k)
        0: irq_lvl = 12'd3 << 3;
        1: irq_en = '0;
        2: i_flag = 1'b0;
        default: begin irq_lvl = '0; ipl = 3'd0; end
      endcase
      @(negedge clk);
      irq_req = '0;
      #5;
      expect_val("R10 near miss stays waiting", 1); observe(int'(in_wait));
    end
    @(negedge clk);
    idle_inputs();
    irq_req = 4'b0100; irq_en = 4'b0100; i_flag = 1'b1; ipl = 3'd5;
    irq_lvl = 12'd6 << 6;
    main_tick = 1'b1;
    // R11 exact restart: wake pulse then first cpu pulse on 4th tick
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      idle_inputs();
      irq_req = '0;
      main_tick = 1'b1;
      #5;
      if (s == 0) begin
        expect_val("R10 wake taken", 0); observe(int'(in_wait));
        expect_val("R11 wake pulse", 1); observe(int'(wake));
      end
      if (s == 1) begin expect_val("R11 wake one cycle", 0); observe(int'(wake)); end
      expect_val("R11 restart cpu_ce", (s == 3) ? 1 : 0); observe(int'(cpu_ce));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule